// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Coherent Two-Part Read

The block keeps a 12-bit count that advances by one on every microsecond tick. The tick comes from a clock divider whose ratio is a parameter: the default of 12 matches a 12 MHz system clock. The count cannot be loaded. It runs from zero after reset and wraps freely.

Software reads the count through an 8-bit register port that has two addresses. The low-byte address returns the lower eight count bits. The same read copies the upper four bits into a holding register. The nibble address returns that holding register and not the live bits, so a low read followed by a nibble read always gives one consistent 12-bit value, even when a carry into the nibble happens between the two reads.

Two interrupt requests come from the count itself. A one-cycle pulse fires each time count bit 6 rises from 0 to 1, which gives a 128 µs period. A second pulse fires each time bit 9 rises, which gives a 1.024 ms period. The block produces only the request pulses; the logic that collects and services them lives elsewhere.

Top module: `usec_timer`

## Requirements
- R1: Reset clears the count, the divider and the holding register. While reset is held, the read data is 0x00 and neither interrupt request is asserted.
- R2: The count advances by exactly one once every CLK_PER_TICK clock cycles (12 by default) and holds its value in all other cycles. After reset is released, the count equals floor(cycles / CLK_PER_TICK).
- R3: After 4095 the count wraps to 0 and keeps running.
- R4: A read at address 0x24 places count[7:0] on rd_data in the cycle after rd_en, using the count value present in the cycle the read was issued.
- R5: A read at address 0x24 copies count[11:8] into the holding register. No other access changes the holding register.
- R6: A read at address 0x25 returns the holding register in bits [3:0] with bits [7:4] zero. It never returns the live upper count bits.
- R7: irq_fast is a single-cycle pulse that occurs only in the cycle after count bit 6 changes from 0 to 1.
- R8: irq_slow is a single-cycle pulse that occurs only in the cycle after count bit 9 changes from 0 to 1.
- R9: A read at any address other than 0x24 or 0x25 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_addr | input | 8 | Register address of the read |
| rd_data | output | 8 | Read result, valid the cycle after rd_en |
| irq_fast | output | 1 | Pulse on each rising edge of count bit 6 |
| irq_slow | output | 1 | Pulse on each rising edge of count bit 9 |

## Verification
The bench tries the read port with four patterns, and each one tells apart a different kind of fault.
- A nibble read straight after reset separates a cleared holding register from a stale one.
- A run of back-to-back low reads across several ticks shows the divider period and a single step per tick, not a double step or a missed one.
- A low read taken at count 255, followed by a nibble read after the carry into bit 8, shows whether the snapshot or the live bits are returned.
- Reads taken around 4095 and around the wrap, plus reads at unused addresses, cover the wrap and the address decode.

The interrupt outputs are compared in every cycle over a full wrap of the count, which covers every rise of bits 6 and 9.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

  // which register a read access selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2
  } rd_sel_e;

  // a level that was 0 and is now 1
  function automatic logic rise_of(input logic was, input logic now);
    return now & ~was;
  endfunction

  // select decode from an address and the two register offsets
  function automatic rd_sel_e decode_sel(input logic [7:0] addr,
                                         input logic [7:0] lo_off,
                                         input logic [7:0] hi_off);
    if (addr == lo_off) return SEL_LOW;
    if (addr == hi_off) return SEL_HIGH;
    return SEL_NONE;
  endfunction

endpackage

// File: rtl/tmr_tick_div.sv
module tmr_tick_div #(
  parameter int CLK_PER_TICK = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_TICK - 1);

  logic [DW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);

  generate
    if (CLK_PER_TICK > 1) begin : g_gap
      // R2: ticks are never adjacent when the ratio exceeds one
      a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != TOP) |=> count == $past(count) + 1'b1);

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == TOP) |=> count == '0);

endmodule

// File: rtl/tmr_rise_det.sv
module tmr_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  import usec_timer_pkg::*;

  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign pulse = rise_of(level_q, level);

endmodule

// File: rtl/tmr_read_port.sv
module tmr_read_port #(
  parameter int CNT_W  = 12,
  parameter int LO_W   = 8,
  parameter int DATA_W = 8,
  parameter logic [7:0] LO_OFF = 8'h24,
  parameter logic [7:0] HI_OFF = 8'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [7:0]        rd_addr,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rd_data
);
  import usec_timer_pkg::*;

  localparam int HI_W = CNT_W - LO_W;

  rd_sel_e          sel;
  logic [HI_W-1:0]  shadow;
  logic             snap;

  assign sel  = rd_en ? decode_sel(rd_addr, LO_OFF, HI_OFF) : SEL_NONE;
  assign snap = (sel == SEL_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n)    shadow <= '0;
    else if (snap) shadow <= count[CNT_W-1:LO_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      case (sel)
        SEL_LOW:  rd_data <= DATA_W'(count[LO_W-1:0]);
        SEL_HIGH: rd_data <= DATA_W'(shadow);
        default:  rd_data <= '0;
      endcase
    end
  end

  // R5: only a low read may move the holding register
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(shadow));

  // R6: the nibble read gives the value held before that read
  a_r6_high_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_HIGH) |=> rd_data == DATA_W'($past(shadow)));

  // R9: an unused address yields zero
  a_r9_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |=> rd_data == '0);

endmodule

// File: rtl/usec_timer.sv
module usec_timer #(
  parameter int CLK_PER_TICK = 12,
  parameter int CNT_W        = 12,
  parameter int LO_W         = 8,
  parameter int FAST_BIT     = 6,
  parameter int SLOW_BIT     = 9,
  parameter logic [7:0] LO_OFF = 8'h24,
  parameter logic [7:0] HI_OFF = 8'h25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq_fast,
  output logic       irq_slow
);
  localparam int NIRQ = 2;
  localparam int IRQ_BIT [NIRQ] = '{FAST_BIT, SLOW_BIT};

  logic             tick;
  logic [CNT_W-1:0] count;
  logic [NIRQ-1:0]  irq_vec;

  tmr_tick_div #(.CLK_PER_TICK(CLK_PER_TICK)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count)
  );

  generate
    for (genvar i = 0; i < NIRQ; i++) begin : g_irq
      tmr_rise_det u_rise (
        .clk(clk), .rst_n(rst_n),
        .level(count[IRQ_BIT[i]]), .pulse(irq_vec[i])
      );
    end
  endgenerate

  assign irq_fast = irq_vec[0];
  assign irq_slow = irq_vec[1];

  tmr_read_port #(
    .CNT_W(CNT_W), .LO_W(LO_W), .DATA_W(8),
    .LO_OFF(LO_OFF), .HI_OFF(HI_OFF)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .count(count), .rd_data(rd_data)
  );

  // R7: fast request follows a fresh rise of its bit and lasts one cycle
  a_r7_fast_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> (count[FAST_BIT] && !$past(count[FAST_BIT])));
  a_r7_fast_once: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |=> !irq_fast);

  // R8: same for the slow request
  a_r8_slow_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_slow |-> (count[SLOW_BIT] && !$past(count[SLOW_BIT])));
  a_r8_slow_once: assert property (@(posedge clk) disable iff (!rst_n)
    irq_slow |=> !irq_slow);

  // R1: no request while reset is applied
  a_r1_quiet: assert property (@(posedge clk)
    !rst_n |=> (!irq_fast && !irq_slow && rd_data == 8'h00));

endmodule

// File: tb/usec_timer_bench.sv
module usec_timer_bench;
  localparam int DIV = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       irq_fast, irq_slow;

  int unsigned edges = 0;
  bit          seen_edge = 1'b0;
  int          vectors = 0;
  int          errs = 0;
  bit          due = 1'b0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [3:0]  shadow_m = 4'h0;

  usec_timer u_usec_timer (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_fast(irq_fast), .irq_slow(irq_slow)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    seen_edge <= 1'b1;
    if (rst_n) edges <= edges + 1;
  end

  function automatic logic [11:0] cval(input int unsigned n);
    return 12'((n / DIV) % 4096);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", req, act, exp, edges);
    end
  endtask

  // driver: issue one read and queue its expected result
  task automatic issue(input logic [7:0] addr, input string req);
    logic [11:0] c;
    logic [7:0]  e;
    @(posedge clk); #1;
    c = cval(edges);
    if (addr == 8'h24) begin
      e = c[7:0];
      shadow_m = c[11:8];
    end else if (addr == 8'h25) e = {4'h0, shadow_m};
    else e = 8'h00;
    exp_q.push_back(e);
    tag_q.push_back(req);
    rd_en = 1'b1;
    rd_addr = addr;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wait_edges(input int unsigned n);
    while (edges < n) @(posedge clk);
  endtask

  // monitor: compare read results and interrupt pulses away from the edge
  always @(negedge clk) begin
    logic [11:0] now_c, was_c;
    if (seen_edge && rst_n) begin
      if (due && exp_q.size() > 0) begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
      now_c = cval(edges);
      was_c = (edges > 0) ? cval(edges - 1) : 12'd0;
      check("R7", {7'd0, irq_fast}, {7'd0, now_c[6] & ~was_c[6]});
      check("R8", {7'd0, irq_slow}, {7'd0, now_c[9] & ~was_c[9]});
    end
    due = rd_en;
  end

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1", rd_data, 8'h00);
    check("R1", {6'd0, irq_fast, irq_slow}, 8'h00);
    @(posedge clk); #1;
    rst_n = 1'b1;

    issue(8'h25, "R1");            // holding register cleared
    issue(8'h24, "R4");
    issue(8'h26, "R9");
    issue(8'h00, "R9");
    issue(8'h25, "R6");

    for (int i = 0; i < 30; i++) issue(8'h24, "R2");

    wait_edges(255 * DIV + 3);
    issue(8'h24, "R4");            // 0xFF, holding nibble 0
    wait_edges(257 * DIV + 2);
    issue(8'h25, "R6");            // still 0 although live nibble is 1
    issue(8'h24, "R5");
    issue(8'h25, "R5");            // now 1

    wait_edges(4095 * DIV + 1);
    issue(8'h24, "R4");
    issue(8'h25, "R6");            // 0xF
    wait_edges(4096 * DIV + 1);
    issue(8'h24, "R3");            // wrapped to 0
    issue(8'h25, "R3");
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule